// File: doc/BRIEF.md
# Multi-Queue Transmit Buffer Front-End

This block sits between a user application and a link transmitter. The application sends framed packets, one beat of two 32-bit DWORDs at a time. Each packet goes into one of 24 transmit queues. The queues are arranged as eight traffic classes, each with three queue types: posted, non-posted and completion. For each queue type the block drives an active-low ready vector with one bit per traffic class, so the application can see at a glance which queues can take a new packet.

The application picks a destination queue with a class field and a type field. The block answers with an active-low destination-ready and a free-space count for that queue. Both answers are registered, so they reflect the select one clock after it changes. The free-space count is delayed further and shows a write four clocks after it. Flow control, however, always uses the exact occupancy.

The block checks start-of-frame and end-of-frame strobes, the per-DWORD enables and the stability of the select within a frame. Any violation sets a sticky error flag. A drain port pops single DWORDs from any queue and returns them one cycle later.

Top module: `txq_front`

## Requirements
- R1: Queue index is type*8+class. The type codes are 00 for posted, 01 for non-posted and 10 for completion. With type code 11 selected, one clock later tx_dst_rdy_n is 1 and ch_space is 0.
- R2: Bit c of rdy_post_n, rdy_npost_n or rdy_cpl_n belongs to class c of that type. The bit is 0 while the queue has at least 4 free DWORDs (out of 64) and 1 otherwise. It updates on the same clock edge that writes or pops the queue.
- R3: tx_dst_rdy_n is 0 exactly when the queue selected in the previous cycle has room for a full beat (at least 2 free DWORDs) after that edge's writes and pops.
- R4: tx_dst_rdy_n and ch_space follow a change of ch_tc/ch_type one clock later, never in the same cycle.
- R5: After a write, ch_space for that queue shows the new free count four clock edges after the accepting edge. ch_space never exceeds 64.
- R6: A beat is accepted on an edge where tx_src_rdy_n and tx_dst_rdy_n are both 0. tx_en_n[i] = 0 marks DWORD lane i (tx_data[32*i+31:32*i]) as valid. The valid lanes must form a run starting at lane 0, and that many DWORDs are stored. An enable of 01 or 11 is an error, and the beat is discarded.
- R7: A change of queue select between start-of-frame and end-of-frame, or a non-start beat outside a frame, sets frame_err. The flag stays set until reset. Later beats of that frame are discarded until the next start-of-frame, which is accepted normally.
- R8: drn_pop with drn_q = q removes the oldest DWORD of queue q. The next cycle shows drn_valid = 1 and that DWORD on drn_data. A pop on an empty queue is ignored, and drn_valid stays 0.
- R9: While rst is 1, and on the first edge after its release, all ready bits and tx_dst_rdy_n read 1, ch_space reads 0 and frame_err reads 0. From the second edge on, all queues are empty and report 64 free DWORDs.
- R10: No queue ever holds more than 64 DWORDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_sof_n | input | 1 | Start-of-frame strobe, active low |
| tx_eof_n | input | 1 | End-of-frame strobe, active low |
| tx_src_rdy_n | input | 1 | Source ready, active low |
| tx_data | input | 64 | Beat data, two DWORD lanes |
| tx_en_n | input | 2 | Per-lane DWORD valid, active low |
| ch_tc | input | 3 | Traffic class select |
| ch_type | input | 2 | Queue type select |
| tx_dst_rdy_n | output | 1 | Selected queue can take a beat, active low |
| ch_space | output | 7 | Free DWORDs of selected queue (lagged) |
| rdy_post_n | output | 8 | Posted queue ready per class, active low |
| rdy_npost_n | output | 8 | Non-posted queue ready per class, active low |
| rdy_cpl_n | output | 8 | Completion queue ready per class, active low |
| frame_err | output | 1 | Sticky framing or select error |
| drn_q | input | 5 | Drain queue index |
| drn_pop | input | 1 | Pop one DWORD |
| drn_valid | output | 1 | Drained DWORD valid |
| drn_data | output | 32 | Drained DWORD |

## Verification
The bench uses the default parameters: eight classes, 64-DWORD queues, two-lane beats, a ready threshold of 4 and a four-edge space lag. A 64-DWORD queue can be filled with a few dozen beats, so a short run reaches the ready threshold, the point where a full beat no longer fits, the pointer wrap and a complete drain. The default lag is short enough to check cycle by cycle, both for the stale reports and for the first cycle of the new value.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    QT_POST  = 2'b00,
    QT_NPOST = 2'b01,
    QT_CPL   = 2'b10,
    QT_NONE  = 2'b11
  } qtype_e;

  localparam int NUM_QTYPE = 3;
endpackage

// File: rtl/txq_lane_ram.sv
module txq_lane_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 768,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txq_space.sv
module txq_space #(
  parameter int NQ     = 24,
  parameter int QW     = 5,
  parameter int QDEPTH = 64,
  parameter int LANES  = 2,
  parameter int LAG    = 4,
  localparam int AW    = $clog2(QDEPTH),
  localparam int CW    = $clog2(QDEPTH + 1),
  localparam int LCW   = $clog2(LANES + 1),
  localparam int NST   = LAG - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_q,
  input  logic [LCW-1:0]   wr_cnt,
  input  logic             pop_req,
  input  logic [QW-1:0]    pop_q,
  output logic             pop_ok,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [NQ*CW-1:0] occ_flat,
  output logic [NQ*CW-1:0] nxt_free_flat,
  output logic [NQ*CW-1:0] rpt_free_flat
);
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);

  logic [CW-1:0] cnt  [NQ];
  logic [CW-1:0] nxt  [NQ];
  logic [AW-1:0] wp   [NQ];
  logic [AW-1:0] rp   [NQ];
  logic [CW-1:0] dly  [NST][NQ];
  logic          pop_in_range;

  assign pop_in_range = (int'(pop_q) < NQ);
  assign pop_ok = pop_req && pop_in_range && (cnt[pop_q] != '0);
  assign wr_ptr = wp[wr_q];
  assign rd_ptr = rp[pop_q];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      nxt[q] = cnt[q];
      if (wr_en && wr_q == QW'(q)) nxt[q] = nxt[q] + CW'(wr_cnt);
      if (pop_ok && pop_q == QW'(q)) nxt[q] = nxt[q] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NQ; q++) begin
        cnt[q] <= '0;
        wp[q]  <= '0;
        rp[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        cnt[q] <= nxt[q];
        if (wr_en && wr_q == QW'(q)) wp[q] <= wp[q] + AW'(wr_cnt);
        if (pop_ok && pop_q == QW'(q)) rp[q] <= rp[q] + 1'b1;
      end
    end
  end

  // Report pipeline: stage 0 samples the settled count, later stages only delay it.
  always_ff @(posedge clk) begin
    for (int s = 0; s < NST; s++) begin
      for (int q = 0; q < NQ; q++) begin
        if (rst)         dly[s][q] <= FULL;
        else if (s == 0) dly[s][q] <= FULL - cnt[q];
        else             dly[s][q] <= dly[s-1][q];
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_flat
    assign occ_flat[q*CW +: CW]      = cnt[q];
    assign nxt_free_flat[q*CW +: CW] = FULL - nxt[q];
    assign rpt_free_flat[q*CW +: CW] = dly[NST-1][q];
  end
endmodule

// File: rtl/txq_frame_ctl.sv
module txq_frame_ctl #(
  parameter int LANES = 2,
  parameter int QW    = 5,
  parameter int CW    = 7,
  localparam int LCW  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof_n,
  input  logic             eof_n,
  input  logic [LANES-1:0] en_n,
  input  logic [QW-1:0]    sel_q,
  input  logic             sel_ok,
  input  logic [CW-1:0]    sel_free,
  output logic             wr_en,
  output logic [LCW-1:0]   wr_cnt,
  output logic             err
);
  logic          in_frame, drop;
  logic [QW-1:0] cur_q;
  logic          contig, good, bad;
  int            vc;

  always_comb begin
    vc     = 0;
    contig = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (!en_n[i]) begin
        if (i != vc) contig = 1'b0;
        vc = vc + 1;
      end
    end
    wr_cnt = LCW'(vc);
    good   = contig && (vc != 0) && sel_ok && (int'(sel_free) >= vc);
  end

  always_comb begin
    wr_en = 1'b0;
    bad   = 1'b0;
    if (beat) begin
      if (!sof_n) begin
        if (good) wr_en = 1'b1;
        else      bad   = 1'b1;
      end else if (!in_frame) begin
        bad = 1'b1;
      end else if (!drop) begin
        if (good && sel_q == cur_q) wr_en = 1'b1;
        else                        bad   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      drop     <= 1'b0;
      cur_q    <= '0;
      err      <= 1'b0;
    end else begin
      if (bad) err <= 1'b1;
      if (beat) begin
        if (!sof_n) begin
          in_frame <= eof_n;
          cur_q    <= sel_q;
          drop     <= bad;
        end else if (in_frame) begin
          if (bad) drop <= 1'b1;
          if (!eof_n) begin
            in_frame <= 1'b0;
            drop     <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/txq_front.sv
module txq_front
  import txq_pkg::*;
#(
  parameter int NUM_TC    = 8,
  parameter int QDEPTH    = 64,
  parameter int LANES     = 2,
  parameter int DW        = 32,
  parameter int RDY_MIN   = 4,
  parameter int SPACE_LAG = 4,
  localparam int NQ   = NUM_TC * NUM_QTYPE,
  localparam int TCW  = $clog2(NUM_TC),
  localparam int QW   = $clog2(NQ + NUM_TC),
  localparam int CW   = $clog2(QDEPTH + 1),
  localparam int AW   = $clog2(QDEPTH),
  localparam int LW   = $clog2(LANES),
  localparam int LCW  = $clog2(LANES + 1),
  localparam int ROWS = QDEPTH / LANES,
  localparam int RAW  = $clog2(NQ * ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_sof_n,
  input  logic                tx_eof_n,
  input  logic                tx_src_rdy_n,
  input  logic [LANES*DW-1:0] tx_data,
  input  logic [LANES-1:0]    tx_en_n,
  input  logic [TCW-1:0]      ch_tc,
  input  logic [1:0]          ch_type,
  output logic                tx_dst_rdy_n,
  output logic [CW-1:0]       ch_space,
  output logic [NUM_TC-1:0]   rdy_post_n,
  output logic [NUM_TC-1:0]   rdy_npost_n,
  output logic [NUM_TC-1:0]   rdy_cpl_n,
  output logic                frame_err,
  input  logic [QW-1:0]       drn_q,
  input  logic                drn_pop,
  output logic                drn_valid,
  output logic [DW-1:0]       drn_data
);
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);

  logic            live;
  logic [QW-1:0]   sel_idx, sidx;
  logic            sel_ok;
  logic [CW-1:0]   sel_free;
  logic            beat;
  logic            wr_en;
  logic [LCW-1:0]  wr_cnt;
  logic            pop_ok;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [NQ*CW-1:0] occ_flat, nxt_free_flat, rpt_free_flat;
  logic [NQ-1:0]   rdy_r;
  logic [LW-1:0]   rd_lane_q;
  logic [DW-1:0]   lane_rd [LANES];

  assign sel_idx  = QW'(ch_type) * QW'(NUM_TC) + QW'(ch_tc);
  assign sel_ok   = (ch_type != QT_NONE);
  assign sidx     = sel_ok ? sel_idx : '0;
  assign sel_free = sel_ok ? (FULL - occ_flat[sidx*CW +: CW]) : '0;
  assign beat     = !tx_src_rdy_n && !tx_dst_rdy_n;

  txq_frame_ctl #(.LANES(LANES), .QW(QW), .CW(CW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .sof_n    (tx_sof_n),
    .eof_n    (tx_eof_n),
    .en_n     (tx_en_n),
    .sel_q    (sel_idx),
    .sel_ok   (sel_ok),
    .sel_free (sel_free),
    .wr_en    (wr_en),
    .wr_cnt   (wr_cnt),
    .err      (frame_err)
  );

  txq_space #(.NQ(NQ), .QW(QW), .QDEPTH(QDEPTH), .LANES(LANES), .LAG(SPACE_LAG)) u_space (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_q          (sel_idx),
    .wr_cnt        (wr_cnt),
    .pop_req       (drn_pop),
    .pop_q         (drn_q),
    .pop_ok        (pop_ok),
    .wr_ptr        (wr_ptr),
    .rd_ptr        (rd_ptr),
    .occ_flat      (occ_flat),
    .nxt_free_flat (nxt_free_flat),
    .rpt_free_flat (rpt_free_flat)
  );

  // One RAM per DWORD lane; DWORD n of a queue lives in lane n mod LANES.
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LW-1:0]  k;
    logic [AW-1:0]  pos;
    logic           we;
    logic [DW-1:0]  wd;
    logic [RAW-1:0] wa, ra;

    always_comb begin
      k   = LW'(j) - wr_ptr[LW-1:0];
      pos = wr_ptr + AW'(k);
      we  = wr_en && (LCW'(k) < wr_cnt);
      wd  = tx_data[DW*k +: DW];
      wa  = RAW'(sel_idx) * RAW'(ROWS) + RAW'(pos[AW-1:LW]);
      ra  = RAW'(drn_q) * RAW'(ROWS) + RAW'(rd_ptr[AW-1:LW]);
    end

    txq_lane_ram #(.W(DW), .DEPTH(NQ * ROWS)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (wa),
      .wdata (wd),
      .raddr (ra),
      .rdata (lane_rd[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live         <= 1'b0;
      rdy_r        <= '1;
      tx_dst_rdy_n <= 1'b1;
      ch_space     <= '0;
      drn_valid    <= 1'b0;
      rd_lane_q    <= '0;
    end else begin
      live <= 1'b1;
      for (int q = 0; q < NQ; q++)
        rdy_r[q] <= !live || (int'(nxt_free_flat[q*CW +: CW]) < RDY_MIN);
      tx_dst_rdy_n <= !(live && sel_ok && (int'(nxt_free_flat[sidx*CW +: CW]) >= LANES));
      ch_space     <= (live && sel_ok) ? rpt_free_flat[sidx*CW +: CW] : '0;
      drn_valid    <= pop_ok;
      rd_lane_q    <= rd_ptr[LW-1:0];
    end
  end

  assign drn_data    = lane_rd[rd_lane_q];
  assign rdy_post_n  = rdy_r[0*NUM_TC +: NUM_TC];
  assign rdy_npost_n = rdy_r[1*NUM_TC +: NUM_TC];
  assign rdy_cpl_n   = rdy_r[2*NUM_TC +: NUM_TC];
endmodule

// File: rtl/txq_front_chk.sv
module txq_front_chk #(
  parameter int NUM_TC  = 8,
  parameter int QDEPTH  = 64,
  parameter int LANES   = 2,
  parameter int RDY_MIN = 4,
  parameter int TCW     = 3,
  parameter int QW      = 5,
  parameter int CW      = 7,
  localparam int NQ     = NUM_TC * 3
) (
  input logic             clk,
  input logic             rst,
  input logic [TCW-1:0]   ch_tc,
  input logic [1:0]       ch_type,
  input logic             tx_dst_rdy_n,
  input logic [CW-1:0]    ch_space,
  input logic             frame_err,
  input logic [NUM_TC-1:0] rdy_post_n,
  input logic [NUM_TC-1:0] rdy_npost_n,
  input logic [NUM_TC-1:0] rdy_cpl_n,
  input logic [NQ*CW-1:0] occ_flat
);
  logic [QW-1:0] cur_idx, prev_idx;
  logic          prev_none;
  int            prev_room;
  logic [NQ-1:0] rdy_all;

  assign cur_idx = QW'(ch_type) * QW'(NUM_TC) + QW'(ch_tc);
  assign rdy_all = {rdy_cpl_n, rdy_npost_n, rdy_post_n};

  always_ff @(posedge clk) begin
    prev_idx  <= cur_idx;
    prev_none <= (ch_type == 2'b11);
  end

  always_comb begin
    prev_room = 0;
    for (int q = 0; q < NQ; q++)
      if (prev_idx == QW'(q)) prev_room = QDEPTH - int'(occ_flat[q*CW +: CW]);
  end

  p_type_none_r1: assert property (@(posedge clk) disable iff (rst)
    (ch_type == 2'b11) |=> (tx_dst_rdy_n && ch_space == '0));

  p_dst_room_r3: assert property (@(posedge clk) disable iff (rst)
    (!tx_dst_rdy_n && !prev_none) |-> (prev_room >= LANES));

  p_space_bound_r5: assert property (@(posedge clk) disable iff (rst)
    int'(ch_space) <= QDEPTH);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&rdy_all && tx_dst_rdy_n && ch_space == '0 && !frame_err));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
      int'(occ_flat[q*CW +: CW]) <= QDEPTH);

    p_ready_room_r2: assert property (@(posedge clk) disable iff (rst)
      !rdy_all[q] |-> (QDEPTH - int'(occ_flat[q*CW +: CW]) >= RDY_MIN));
  end
endmodule

bind txq_front txq_front_chk #(
  .NUM_TC(NUM_TC), .QDEPTH(QDEPTH), .LANES(LANES), .RDY_MIN(RDY_MIN),
  .TCW(TCW), .QW(QW), .CW(CW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ch_tc        (ch_tc),
  .ch_type      (ch_type),
  .tx_dst_rdy_n (tx_dst_rdy_n),
  .ch_space     (ch_space),
  .frame_err    (frame_err),
  .rdy_post_n   (rdy_post_n),
  .rdy_npost_n  (rdy_npost_n),
  .rdy_cpl_n    (rdy_cpl_n),
  .occ_flat     (occ_flat)
);

// File: tb/tb_txq_front.sv
module tb_txq_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_sof_n = 1'b1, tx_eof_n = 1'b1, tx_src_rdy_n = 1'b1;
  logic [63:0] tx_data = '0;
  logic [1:0]  tx_en_n = 2'b11;
  logic [2:0]  ch_tc = '0;
  logic [1:0]  ch_type = '0;
  logic        tx_dst_rdy_n;
  logic [6:0]  ch_space;
  logic [7:0]  rdy_post_n, rdy_npost_n, rdy_cpl_n;
  logic        frame_err;
  logic [4:0]  drn_q = '0;
  logic        drn_pop = 1'b0;
  logic        drn_valid;
  logic [31:0] drn_data;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  int          mcnt [24];
  int          mwp  [24];
  int          mrp  [24];
  logic [31:0] bm   [24][64];

  always #5 clk = ~clk;

  txq_front dut (
    .clk(clk), .rst(rst), .tx_sof_n(tx_sof_n), .tx_eof_n(tx_eof_n),
    .tx_src_rdy_n(tx_src_rdy_n), .tx_data(tx_data), .tx_en_n(tx_en_n),
    .ch_tc(ch_tc), .ch_type(ch_type), .tx_dst_rdy_n(tx_dst_rdy_n),
    .ch_space(ch_space), .rdy_post_n(rdy_post_n), .rdy_npost_n(rdy_npost_n),
    .rdy_cpl_n(rdy_cpl_n), .frame_err(frame_err), .drn_q(drn_q),
    .drn_pop(drn_pop), .drn_valid(drn_valid), .drn_data(drn_data)
  );

  // {class[12:10], type[9:8], beats[7:2], DWORDs in last beat[1:0]}
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 2'd0, 6'd3, 2'd2}, {3'd1, 2'd1, 6'd1, 2'd1},
    {3'd7, 2'd2, 6'd5, 2'd1}, {3'd3, 2'd0, 6'd4, 2'd2},
    {3'd0, 2'd0, 6'd2, 2'd1}, {3'd5, 2'd1, 6'd8, 2'd2},
    {3'd6, 2'd2, 6'd1, 2'd2}, {3'd2, 2'd1, 6'd6, 2'd1}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int q = 0; q < 24; q++) begin
      mcnt[q] = 0; mwp[q] = 0; mrp[q] = 0;
    end
  endtask

  function automatic logic [7:0] exp_rdy(input int ty);
    logic [7:0] v;
    for (int t = 0; t < 8; t++) v[t] = ((64 - mcnt[ty*8+t]) < 4);
    return v;
  endfunction

  task automatic set_sel(input int tc, input int ty);
    ch_tc = 3'(tc); ch_type = 2'(ty);
    @(negedge clk);
  endtask

  task automatic put_beat(input bit sof, input bit eof, input logic [1:0] en, input logic [63:0] d);
    bit acc;
    tx_sof_n = !sof; tx_eof_n = !eof; tx_en_n = en; tx_data = d; tx_src_rdy_n = 1'b0;
    do begin
      acc = !tx_dst_rdy_n;
      @(negedge clk);
    end while (!acc);
    tx_src_rdy_n = 1'b1; tx_sof_n = 1'b1; tx_eof_n = 1'b1; tx_en_n = 2'b11;
  endtask

  task automatic model_push(input int q, input logic [1:0] en, input logic [63:0] d);
    for (int k = 0; k < 2; k++) begin
      if (!en[k]) begin
        bm[q][mwp[q]] = d[k*32 +: 32];
        mwp[q] = (mwp[q] + 1) % 64;
        mcnt[q]++;
      end
    end
  endtask

  task automatic send_frame(input int tc, input int ty, input int nb, input int lc);
    int q;
    logic [1:0]  en;
    logic [63:0] d;
    q = ty * 8 + tc;
    for (int b = 0; b < nb; b++) begin
      en = (b == nb - 1 && lc == 1) ? 2'b10 : 2'b00;
      d  = {8'(q), 8'(b), 8'(mwp[q]), 8'hA1, 8'(q), 8'(b), 8'(mwp[q]), 8'h5C};
      put_beat(b == 0, b == nb - 1, en, d);
      model_push(q, en, d);
    end
  endtask

  task automatic pop_one(input int q, input string req);
    drn_q = 5'(q); drn_pop = 1'b1;
    @(negedge clk);
    drn_pop = 1'b0;
    chk(req, "drain valid", drn_valid, 1);
    chk(req, "drain data", drn_data, bm[q][mrp[q]]);
    mrp[q] = (mrp[q] + 1) % 64;
    mcnt[q]--;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R9", "post ready first edge", rdy_post_n, 8'hFF);
    chk("R9", "cpl ready first edge", rdy_cpl_n, 8'hFF);
    chk("R9", "dst ready first edge", tx_dst_rdy_n, 1);
    chk("R9", "space first edge", ch_space, 0);
    @(negedge clk);
    chk("R9", "post ready second edge", rdy_post_n, 8'h00);
    chk("R9", "npost ready second edge", rdy_npost_n, 8'h00);
    chk("R9", "dst ready second edge", tx_dst_rdy_n, 0);
    chk("R9", "space second edge", ch_space, 64);
    chk("R9", "error cleared", frame_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();

    // Table walk: R1 queue mapping, R2 ready vectors, R5 settled space, R6 lane counts.
    for (int i = 0; i < 8; i++) begin
      int tc, ty, nb, lc, q;
      tc = int'(VEC[i][12:10]); ty = int'(VEC[i][9:8]);
      nb = int'(VEC[i][7:2]);   lc = int'(VEC[i][1:0]);
      q  = ty * 8 + tc;
      set_sel(tc, ty);
      send_frame(tc, ty, nb, lc);
      repeat (4) @(negedge clk);
      chk("R5", "table space", ch_space, 64 - mcnt[q]);
      chk("R3", "table dst ready", tx_dst_rdy_n, 0);
      chk("R2", "table posted vector", rdy_post_n, exp_rdy(0));
      chk("R1", "table non-posted vector", rdy_npost_n, exp_rdy(1));
      chk("R1", "table completion vector", rdy_cpl_n, exp_rdy(2));
    end

    // R5: exact four-edge lag on class 4 posted
    set_sel(4, 0);
    chk("R5", "empty space", ch_space, 64);
    send_frame(4, 0, 1, 2);
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk);
      chk("R5", "stale space", ch_space, 64);
    end
    @(negedge clk);
    chk("R5", "new space at lag", ch_space, 62);

    // R4: one-cycle select lag
    ch_tc = 3'd1; ch_type = 2'd1;
    #1;
    chk("R4", "space before edge", ch_space, 62);
    @(negedge clk);
    chk("R4", "space after edge", ch_space, 63);
    ch_type = 2'd3;
    #1;
    chk("R4", "dst before edge", tx_dst_rdy_n, 0);
    @(negedge clk);
    chk("R1", "type 11 dst", tx_dst_rdy_n, 1);
    chk("R1", "type 11 space", ch_space, 0);

    // R2/R3: threshold and full-beat room on class 2 posted
    set_sel(2, 0);
    send_frame(2, 0, 30, 2);
    repeat (4) @(negedge clk);
    chk("R2", "ready at 4 free", rdy_post_n[2], 0);
    chk("R5", "space at 4 free", ch_space, 4);
    send_frame(2, 0, 1, 1);
    chk("R2", "ready drops at 3 free", rdy_post_n[2], 1);
    chk("R3", "dst at 3 free", tx_dst_rdy_n, 0);
    send_frame(2, 0, 1, 1);
    chk("R3", "dst at 2 free", tx_dst_rdy_n, 0);
    send_frame(2, 0, 1, 1);
    chk("R3", "dst at 1 free", tx_dst_rdy_n, 1);
    chk("R10", "posted vector when nearly full", rdy_post_n, exp_rdy(0));

    // R8: drain back in order
    pop_one(2, "R8");
    chk("R3", "dst after pop", tx_dst_rdy_n, 0);
    pop_one(2, "R8");
    pop_one(2, "R8");
    chk("R2", "ready back at 4 free", rdy_post_n[2], 0);
    while (mcnt[2] > 0) pop_one(2, "R8");
    drn_q = 5'd2; drn_pop = 1'b1;
    @(negedge clk);
    drn_pop = 1'b0;
    chk("R8", "pop on empty ignored", drn_valid, 0);
    repeat (4) @(negedge clk);
    chk("R8", "space after full drain", ch_space, 64);

    // R7: select change inside a frame
    chk("R7", "no error yet", frame_err, 0);
    set_sel(3, 2);
    put_beat(1, 0, 2'b00, 64'h1111_2222_3333_4444);
    model_push(19, 2'b00, 64'h1111_2222_3333_4444);
    ch_type = 2'd1;
    put_beat(0, 0, 2'b00, 64'h5555_6666_7777_8888);
    chk("R7", "error on select change", frame_err, 1);
    set_sel(3, 2);
    put_beat(0, 1, 2'b00, 64'h9999_AAAA_BBBB_CCCC);
    repeat (4) @(negedge clk);
    chk("R7", "rest of frame dropped", ch_space, 62);
    set_sel(3, 1);
    chk("R7", "other queue untouched", ch_space, 64);
    put_beat(0, 1, 2'b00, 64'h0);
    set_sel(3, 2);
    send_frame(3, 2, 1, 2);
    repeat (4) @(negedge clk);
    chk("R7", "next start accepted", ch_space, 60);
    chk("R7", "error stays set", frame_err, 1);

    do_reset();

    // R6: invalid enable patterns
    set_sel(0, 2);
    put_beat(1, 1, 2'b01, 64'hDEAD_BEEF_0000_0001);
    chk("R6", "gap enable error", frame_err, 1);
    put_beat(1, 1, 2'b11, 64'hDEAD_BEEF_0000_0002);
    repeat (4) @(negedge clk);
    chk("R6", "bad beats discarded", ch_space, 64);
    send_frame(0, 2, 1, 1);
    repeat (4) @(negedge clk);
    chk("R6", "single lane stored", ch_space, 63);
    pop_one(16, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule